// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves incoming frame bytes into buffers described by a circular chain of receive descriptors. Descriptors and buffers share one internal 32-bit word memory. Software reaches that memory through a plain read/write word port. The engine reaches it through a second port with byte enables. Software builds the ring and loads the address of the first descriptor while the engine is stopped, then issues a start command. From then on the engine reads a descriptor, waits for a frame, stores its bytes, writes a completion status back and follows the descriptor's link to the next one.

Each descriptor has four consecutive words: status, buffer word address, buffer length in bytes, and the word address of the next descriptor. The engine fills a descriptor only while its ownership bit is set, and clears that bit when the frame is complete. If the descriptor it reaches belongs to software, the engine raises a no-buffer flag and discards incoming frames. It stays that way until software returns the descriptor and issues a queue command. Frames arrive one byte per cycle with a last-byte marker and an error flag. Consecutive frames must be separated by at least six idle cycles, which gives the engine time to write back the status and fetch the next descriptor.

Top module: `rxd_ring_dma`

## Requirements
- R1: A descriptor occupies four words at offsets 0 to 3 from its word address: status, buffer word address (bits [ADDR_W-1:0]), buffer length in bytes (bits [15:0]) and next-descriptor word address (bits [ADDR_W-1:0]).
- R2: The engine stores frame data into a descriptor only if status bit 15 (ownership) was set when the descriptor was read. The completion write sets that bit to 0.
- R3: After a completion the engine fetches the descriptor named by the link word, never the next word address, so a ring whose last link points to the first one wraps around.
- R4: Frame byte n is stored at word (buffer address + n/4), byte lane n mod 4, which is bits [8*(n mod 4)+7 : 8*(n mod 4)]. Other lanes of that word keep their contents.
- R5: The completion status holds the total received byte count, CRC bytes included, in bits [31:16]. Bit 0 is 1 when none of the flags of R6 and R7 is set.
- R6: Status bit 1 is set when the error input was high on any byte of the frame. Status bit 2 is set when the byte count is below MIN_LEN.
- R7: Status bit 13 is set when the byte count exceeds the buffer length. Bytes at positions at or beyond the buffer length are not written.
- R8: While the current descriptor is not owned, no_buf is high, frames are discarded and no memory write occurs. A queue command makes the engine re-read the same descriptor.
- R9: A write on the base port while the engine is stopped sets the first descriptor address. A start command begins fetching there.
- R10: For each completed frame, frame_done pulses for one cycle, and frame_status carries the same word that was written to the descriptor's status.
- R11: A software write stores a full word. sw_rdata shows the word at sw_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software word write strobe |
| sw_addr | input | ADDR_W | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle after address |
| base_we | input | 1 | Load first descriptor address (stopped only) |
| base_addr | input | ADDR_W | First descriptor word address |
| cmd_start | input | 1 | Start receiving |
| cmd_queue | input | 1 | Re-check current descriptor after a no-buffer stall |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 1 | Receive error on this byte |
| frame_done | output | 1 | One-cycle completion pulse |
| frame_status | output | 32 | Status word of the completed frame |
| no_buf | output | 1 | Current descriptor not owned by the engine |

## Verification
The bench builds the engine with ADDR_W = 8 and MIN_LEN = 8. With these values, frames of five to twelve bytes are enough to cover the runt, clean and error cases. Buffer lengths of six and sixteen bytes make a giant frame reachable with a ten-byte frame, and make the preserved bytes beyond the buffer visible. The ring uses two descriptors placed apart, at addresses that are not adjacent. The bench lets both come back to software, which drives the engine through the wrap, the no-buffer stall and its release by a queue command.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int LEN_W     = 16;
  localparam int OWN_BIT   = 15;
  localparam int GIANT_BIT = 13;
  localparam int RUNT_BIT  = 2;
  localparam int ERR_BIT   = 1;
  localparam int GOOD_BIT  = 0;

  typedef enum logic [3:0] {
    S_OFF,
    S_RD_STAT,
    S_RD_BUF,
    S_RD_LEN,
    S_RD_NEXT,
    S_WAIT,
    S_RECV,
    S_WB,
    S_NOBUF
  } rxd_state_e;

  function automatic logic [31:0] make_status(input logic [LEN_W-1:0] len,
                                              input logic giant,
                                              input logic err,
                                              input logic runt);
    logic [31:0] s;
    s             = '0;
    s[31:16]      = len;
    s[GIANT_BIT]  = giant;
    s[RUNT_BIT]   = runt;
    s[ERR_BIT]    = err;
    s[GOOD_BIT]   = !(giant || err || runt);
    return s;
  endfunction

endpackage

// File: rtl/rxd_mem.sv
module rxd_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [AW-1:0] eng_addr,
  output logic [31:0]   eng_rdata,
  input  logic          eng_we,
  input  logic [3:0]    eng_be,
  input  logic [31:0]   eng_wdata
);

  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  assign eng_rdata = mem[eng_addr];

  // Engine lanes are written after the software word, so they win on a clash.
  always_ff @(posedge clk) begin
    if (sw_we) begin
      mem[sw_addr] <= sw_wdata;
    end
    if (eng_we) begin
      for (int i = 0; i < 4; i++) begin
        if (eng_be[i]) begin
          mem[eng_addr][8*i +: 8] <= eng_wdata[8*i +: 8];
        end
      end
    end
    sw_rdata <= mem[sw_addr];
  end

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer import rxd_pkg::*; #(
  parameter int AW      = 8,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_err,
  input  logic [AW-1:0]    buf_ptr,
  input  logic [LEN_W-1:0] buf_len,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [3:0]       wr_be,
  output logic [31:0]      wr_data,
  output logic [31:0]      sts_word
);

  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             err_q, err_d;
  logic [31:0]      sts_q, sts_d;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + LEN_W'(1);
    wr_en   = accept && (cnt_q < buf_len);
    wr_addr = buf_ptr + AW'(cnt_q >> 2);
    wr_be   = 4'b0001 << cnt_q[1:0];
    wr_data = {4{in_data}};

    cnt_d = cnt_q;
    err_d = err_q;
    sts_d = sts_q;
    if (clr) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (accept) begin
      if (in_last) begin
        sts_d = make_status(cnt_inc, cnt_inc > buf_len,
                            err_q || in_err, cnt_inc < MIN_L);
        cnt_d = '0;
        err_d = 1'b0;
      end else begin
        cnt_d = cnt_inc;
        err_d = err_q || in_err;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      sts_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
      sts_q <= sts_d;
    end
  end

  assign sts_word = sts_q;

  // R7: a frame that runs past its buffer carries the giant flag
  p_giant_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last && !clr && (cnt_q >= buf_len)) |=> sts_q[GIANT_BIT]);

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl import rxd_pkg::*; #(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_queue,
  input  logic             base_we,
  input  logic [AW-1:0]    base_addr,
  input  logic [31:0]      rd_data,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [31:0]      sts_word,
  output logic [AW-1:0]    rd_addr,
  output logic             accept,
  output logic             st_we,
  output logic             pk_clr,
  output logic [AW-1:0]    buf_ptr,
  output logic [LEN_W-1:0] buf_len,
  output logic             no_buf,
  output logic             frame_done,
  output logic [31:0]      frame_status
);

  rxd_state_e       st_q, st_d;
  logic [AW-1:0]    cur_q, buf_q, nxt_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic [31:0]      fsts_q;
  logic             unused_hi;

  assign unused_hi = ^rd_data[31:16];

  always_comb begin
    st_d    = st_q;
    rd_addr = cur_q;
    accept  = 1'b0;
    st_we   = 1'b0;
    case (st_q)
      S_OFF:     if (cmd_start) st_d = S_RD_STAT;
      S_RD_STAT: st_d = rd_data[OWN_BIT] ? S_RD_BUF : S_NOBUF;
      S_RD_BUF: begin
        rd_addr = cur_q + AW'(1);
        st_d    = S_RD_LEN;
      end
      S_RD_LEN: begin
        rd_addr = cur_q + AW'(2);
        st_d    = S_RD_NEXT;
      end
      S_RD_NEXT: begin
        rd_addr = cur_q + AW'(3);
        st_d    = S_WAIT;
      end
      S_WAIT, S_RECV: begin
        accept = in_valid;
        if (in_valid) st_d = in_last ? S_WB : S_RECV;
      end
      S_WB: begin
        st_we = 1'b1;
        st_d  = S_RD_STAT;
      end
      S_NOBUF:   if (cmd_queue) st_d = S_RD_STAT;
      default:   st_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_OFF;
      cur_q  <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      nxt_q  <= '0;
      done_q <= 1'b0;
      fsts_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == S_WB);
      if (st_q == S_OFF && base_we) begin
        cur_q <= base_addr;
      end else if (st_q == S_WB) begin
        cur_q <= nxt_q;
      end
      if (st_q == S_RD_BUF)  buf_q <= rd_data[AW-1:0];
      if (st_q == S_RD_LEN)  len_q <= rd_data[LEN_W-1:0];
      if (st_q == S_RD_NEXT) nxt_q <= rd_data[AW-1:0];
      if (st_q == S_WB)      fsts_q <= sts_word;
    end
  end

  assign pk_clr       = (st_q == S_RD_NEXT);
  assign buf_ptr      = buf_q;
  assign buf_len      = len_q;
  assign no_buf       = (st_q == S_NOBUF);
  assign frame_done   = done_q;
  assign frame_status = fsts_q;

  // R2: data phase only after the memory reported the ownership bit set
  p_owned_before_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD_BUF) |-> $past(rd_data[OWN_BIT]));

  // R3: the descriptor after a completion is the one named by its link
  p_follow_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD_STAT && $past(st_q) == S_WB) |-> (cur_q == $past(nxt_q)));

endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma import rxd_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int MIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              cmd_start,
  input  logic              cmd_queue,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              frame_done,
  output logic [31:0]       frame_status,
  output logic              no_buf
);

  logic [ADDR_W-1:0] ctl_addr, pk_addr, buf_ptr, eng_addr;
  logic [LEN_W-1:0]  buf_len;
  logic [31:0]       eng_rdata, pk_data, sts_word, eng_wdata;
  logic [3:0]        pk_be, eng_be;
  logic              accept, st_we, pk_clr, pk_we, eng_we;

  rxd_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .cmd_queue    (cmd_queue),
    .base_we      (base_we),
    .base_addr    (base_addr),
    .rd_data      (eng_rdata),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .sts_word     (sts_word),
    .rd_addr      (ctl_addr),
    .accept       (accept),
    .st_we        (st_we),
    .pk_clr       (pk_clr),
    .buf_ptr      (buf_ptr),
    .buf_len      (buf_len),
    .no_buf       (no_buf),
    .frame_done   (frame_done),
    .frame_status (frame_status)
  );

  rxd_packer #(.AW(ADDR_W), .MIN_LEN(MIN_LEN)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pk_clr),
    .accept   (accept),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_err   (in_err),
    .buf_ptr  (buf_ptr),
    .buf_len  (buf_len),
    .wr_en    (pk_we),
    .wr_addr  (pk_addr),
    .wr_be    (pk_be),
    .wr_data  (pk_data),
    .sts_word (sts_word)
  );

  always_comb begin
    eng_we    = pk_we || st_we;
    eng_addr  = pk_we ? pk_addr : ctl_addr;
    eng_be    = st_we ? 4'hF : pk_be;
    eng_wdata = st_we ? sts_word : pk_data;
  end

  rxd_mem #(.AW(ADDR_W)) u_mem (
    .clk       (clk),
    .sw_we     (sw_we),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .eng_addr  (eng_addr),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_be    (eng_be),
    .eng_wdata (eng_wdata)
  );

  // R8: a stalled engine leaves memory alone
  p_nobuf_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |-> !eng_we);

  // R2: a reported completion has handed the descriptor back
  p_done_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_status[OWN_BIT]);

  // R4: data stores touch exactly one byte lane
  p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !st_we) |-> ($countones(eng_be) == 1));

endmodule

// File: tb/rxd_ring_dma_bench.sv
`timescale 1ns/1ps
module rxd_ring_dma_bench;

  localparam int AW = 8;
  localparam int D0 = 'h10, D1 = 'h20, B0 = 'h40, B1 = 'h60;

  logic          clk, rst_n;
  logic          sw_we, base_we, cmd_start, cmd_queue;
  logic [AW-1:0] sw_addr, base_addr;
  logic [31:0]   sw_wdata, sw_rdata, frame_status;
  logic          in_valid, in_last, in_err, frame_done, no_buf;
  logic [7:0]    in_data;

  int n_chk, n_fail, done_cnt;
  logic [31:0] last_sts;

  rxd_ring_dma #(.ADDR_W(AW), .MIN_LEN(8)) u_rxd_ring_dma (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .base_we(base_we),
    .base_addr(base_addr), .cmd_start(cmd_start), .cmd_queue(cmd_queue),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .frame_done(frame_done), .frame_status(frame_status),
    .no_buf(no_buf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && frame_done) begin
      done_cnt = done_cnt + 1;
      last_sts = frame_status;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = AW'(a); sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    sw_addr = AW'(a);
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic pulse_queue();
    @(negedge clk); cmd_queue = 1'b1;
    @(negedge clk); cmd_queue = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [7:0] v0, input int err_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = v0 + 8'(i);
      in_last = (i == n - 1); in_err = (i == err_at);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] wpack(input logic [7:0] v0, input int w);
    return {v0 + 8'(4*w+3), v0 + 8'(4*w+2), v0 + 8'(4*w+1), v0 + 8'(4*w)};
  endfunction

  task automatic t_reset();
    chk("R8 reset no_buf", {31'b0, no_buf}, 32'd0);
    chk("R10 reset frame_done", {31'b0, frame_done}, 32'd0);
  endtask

  task automatic t_swport();
    logic [31:0] d;
    wr('h80, 32'h1234_5678);
    rd('h80, d);
    chk("R11 software readback", d, 32'h1234_5678);
  endtask

  task automatic t_ring_start();
    wr(D0, 32'h0000_8000); wr(D0+1, B0); wr(D0+2, 16); wr(D0+3, D1);
    wr(D1, 32'h0000_8000); wr(D1+1, B1); wr(D1+2, 16); wr(D1+3, D0);
    wr(B0+3, 32'hDEAD_BEEF);
    @(negedge clk); base_we = 1'b1; base_addr = AW'(D0);
    @(negedge clk); base_we = 1'b0; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 engine armed, no stall", {31'b0, no_buf}, 32'd0);
  endtask

  task automatic t_clean_frame();
    logic [31:0] d;
    send(12, 8'hA0, -1);
    chk("R10 one completion", done_cnt, 1);
    chk("R10 frame_status clean", last_sts, (32'd12 << 16) | 32'h1);
    rd(D0, d);
    chk("R5 status word written", d, (32'd12 << 16) | 32'h1);
    for (int w = 0; w < 3; w++) begin
      rd(B0 + w, d);
      chk("R4 data word", d, wpack(8'hA0, w));
    end
    rd(B0+3, d);
    chk("R4 word past frame untouched", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_err_frame();
    logic [31:0] d;
    send(9, 8'hB0, 4);
    chk("R3 second completion", done_cnt, 2);
    rd(D1, d);
    chk("R6 error bit via link", d, (32'd9 << 16) | 32'h2);
    rd(B1 + 2, d);
    chk("R4 ninth byte lane 0", d[7:0], 32'(8'hB8));
  endtask

  task automatic t_nobuf_drop();
    logic [31:0] d;
    chk("R8 wrapped to released desc", {31'b0, no_buf}, 32'd1);
    send(10, 8'hE0, -1);
    chk("R8 no completion while stalled", done_cnt, 2);
    rd(B0, d);
    chk("R8 buffer untouched", d, wpack(8'hA0, 0));
  endtask

  task automatic t_giant();
    logic [31:0] d;
    wr(D0+2, 6); wr(D0, 32'h0000_8000);
    pulse_queue();
    chk("R8 queue releases stall", {31'b0, no_buf}, 32'd0);
    send(10, 8'hC0, -1);
    chk("R7 giant status", last_sts, (32'd10 << 16) | 32'h2000);
    rd(B0, d);
    chk("R7 first word stored", d, wpack(8'hC0, 0));
    rd(B0 + 1, d);
    chk("R7 lanes past length kept", d, {8'hA7, 8'hA6, 8'hC5, 8'hC4});
    rd(B0 + 2, d);
    chk("R7 word past length kept", d, wpack(8'hA0, 2));
  endtask

  task automatic t_runt();
    logic [31:0] d;
    chk("R3 next desc released, stalled", {31'b0, no_buf}, 32'd1);
    wr(D1, 32'h0000_8000);
    pulse_queue();
    send(5, 8'h50, -1);
    rd(D1, d);
    chk("R6 runt bit", d, (32'd5 << 16) | 32'h4);
    chk("R2 own cleared", {31'b0, d[15]}, 32'd0);
    chk("R1 stall again after ring", {31'b0, no_buf}, 32'd1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done_cnt = 0; last_sts = '0;
    rst_n = 1'b0; sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
    base_we = 1'b0; base_addr = '0; cmd_start = 1'b0; cmd_queue = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swport();
    t_ring_start();
    t_clean_frame();
    t_err_frame();
    t_nobuf_drop();
    t_giant();
    t_runt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule